// File: doc/BRIEF.md
# Byte-Serial SPI Master Shift Engine

This block is the byte-level core of an SPI master. It holds a 64-byte transmit queue and a 64-byte receive queue. Software reaches it through a plain register read/write port. Once the engine is enabled and a start request is written, it clocks a burst of bytes out on the serial data line. The first part of the burst is taken from the transmit queue. The rest is zero padding, and its length is set by a second counter. Bytes captured from the serial input are placed in the receive queue unless the discard option is set. At the end of the burst the engine clears its own start bit and raises a completion flag, which can drive an interrupt.

The serial clock rate is not produced here. A separate divider supplies `halfTick`, a one-cycle pulse for each half period of the serial clock. The engine advances one serial clock edge per pulse. Chip-select generation is also outside this block.

Register offsets (byte addresses): 0x00 receive data (a read pops one byte), 0x04 transmit data (a write pushes one byte), 0x08 control, 0x0C interrupt enable, 0x10 interrupt status, 0x14 burst length, 0x18 transmit length, 0x1C queue levels.

Top module: `spi_byte_engine`

## Requirements
- R1: After reset the control word, the interrupt enable, the interrupt status and both queue levels read as zero, `irq` is 0, `sclk` is 0 and `mosi` is 0.
- R2: A write to offset 0x04 pushes `regWdata[7:0]` into the transmit queue. Offset 0x1C reports the receive level in bits 6:0 and the transmit level in bits 22:16, each counting 0 to 64. A push to a full queue is ignored.
- R3: Writing 1 to control bit 8 empties the transmit queue and writing 1 to bit 9 empties the receive queue. Both bits read back as 0.
- R4: Control bits are: 0 enable, 1 master, 2 clock phase, 3 clock polarity, 6 LSB-first, 10 start, 15 discard. A write with bit 10 and bit 0 both set launches a burst. A write of bit 10 with bit 0 clear has no effect: bit 10 reads 0 and no status is raised.
- R5: While no burst runs, `sclk` equals control bit 3. During a burst each byte takes 16 `halfTick` pulses, and `sclk` changes only after a pulse.
- R6: Bits go out MSB first, or LSB first when control bit 6 is set. With bit 2 clear, data is valid before the leading clock edge and is sampled on it. With bit 2 set, data changes on the leading edge and is sampled on the trailing edge.
- R7: Each received byte is assembled in the same bit order and pushed into the receive queue. A read of offset 0x00 returns the oldest byte and pops it. A read of an empty queue returns 0.
- R8: The 24-bit burst length (0x14) sets the total bytes clocked. The first (24-bit transmit length, 0x18) of them are popped from the transmit queue and the remainder are sent as 0x00. A transmit length of 0 sends only zero bytes.
- R9: With control bit 15 set, no received byte of the burst enters the receive queue.
- R10: When the last byte ends, control bit 10 clears and status bit 16 sets. `irq` is the AND of enable bit 16 and status bit 16. Writing 1 to status bit 16 clears it and writing 0 leaves it set.
- R11: A burst length of 0 completes at once with no serial clock edge and still sets status bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops the receive queue at 0x00) |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from `regAddr` |
| halfTick | input | 1 | Half-period pulse from the external clock divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bound checker watches four things on every cycle: the queue levels never go past the depth, the idle clock sits at the polarity level, the clock never moves without a half-period pulse, and a launch always has the enable bit behind it. It also checks that every drop of the busy state comes with the completion flag, and that discard mode never lets the receive level grow. Bit order, the leading/trailing edge choice for each clock mode, the split between queued bytes and zero padding, and the received byte values can only be shown by the bench scenarios. There, a wire monitor decodes `mosi` on the sample edges and compares the result with a scoreboard, and an inverting loopback on `miso` shows what lands in the receive queue.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int XFER_W = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 5;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_RXDATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TXDATA = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_ISTA   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_BURST  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_TXLEN  = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 5'h1C;

  // control word bit positions (software decodes these)
  localparam int CB_EN      = 0;
  localparam int CB_MASTER  = 1;
  localparam int CB_CPHA    = 2;
  localparam int CB_CPOL    = 3;
  localparam int CB_LSB     = 6;
  localparam int CB_TXRST   = 8;
  localparam int CB_RXRST   = 9;
  localparam int CB_START   = 10;
  localparam int CB_DISCARD = 15;
  localparam int IB_DONE    = 16;
  localparam int LB_TXLVL   = 16;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic lsbFirst;
  } modeCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrTx;
    logic clrRx;
    logic pushTx;
    logic popRx;
    logic loadByte;
    logic takeTx;
    logic leadEdge;
    logic trailEdge;
    logic pushRx;
    logic active;
    logic shifting;
  } dpStrobe_t;

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic             isEmpty, isFull, doPush, doPop;

  assign isEmpty = (level == '0);
  assign isFull  = (level == LVL_W'(DEPTH));
  assign doPush  = push && !isFull;
  assign doPop   = pop && !isEmpty;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrNext;
      if (doPop)  rdPtr <= rdNext;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  assign head = isEmpty ? '0 : mem[rdPtr];

endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  modeCfg_t          modeCfg,
  input  logic [XFER_W-1:0] txWdata,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic [XFER_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel
);

  logic [XFER_W-1:0] txHead, txShift, txShifted, rxShift, rxShifted;
  logic              outBit, mosiHold, sclkQ, sampleEdge, launchEdge;

  spi_eng_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(strobe.clrTx), .push(strobe.pushTx),
    .pop(strobe.takeTx), .wdata(txWdata), .head(txHead), .level(txLevel)
  );

  spi_eng_fifo #(.W(XFER_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(strobe.clrRx), .push(strobe.pushRx),
    .pop(strobe.popRx), .wdata(rxShift), .head(rxHead), .level(rxLevel)
  );

  always_comb begin
    outBit     = modeCfg.lsbFirst ? txShift[0] : txShift[XFER_W-1];
    txShifted  = modeCfg.lsbFirst ? {1'b0, txShift[XFER_W-1:1]}
                                  : {txShift[XFER_W-2:0], 1'b0};
    rxShifted  = modeCfg.lsbFirst ? {miso, rxShift[XFER_W-1:1]}
                                  : {rxShift[XFER_W-2:0], miso};
    sampleEdge = modeCfg.cpha ? strobe.trailEdge : strobe.leadEdge;
    launchEdge = modeCfg.cpha ? strobe.leadEdge  : strobe.trailEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      mosiHold <= 1'b0;
      sclkQ    <= 1'b0;
    end else if (strobe.loadByte) begin
      txShift  <= strobe.takeTx ? txHead : '0;
      mosiHold <= 1'b0;
      sclkQ    <= modeCfg.cpol;
    end else begin
      if (launchEdge) begin
        txShift <= txShifted;
        if (modeCfg.cpha) mosiHold <= outBit;
      end
      if (sampleEdge) rxShift <= rxShifted;
      if (strobe.leadEdge)       sclkQ <= ~modeCfg.cpol;
      else if (strobe.trailEdge) sclkQ <= modeCfg.cpol;
    end
  end

  assign mosi = !strobe.active ? 1'b0 : (modeCfg.cpha ? mosiHold : outBit);
  assign sclk = strobe.shifting ? sclkQ : modeCfg.cpol;

endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LVL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              halfTick,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [XFER_W-1:0] rxHead,
  output dpStrobe_t         strobe,
  output modeCfg_t          modeCfg,
  output logic              busy,
  output logic              enCfg,
  output logic              discardCfg,
  output logic              doneSta,
  output logic              irq
);

  localparam int HALF_W = $clog2(2 * XFER_W);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * XFER_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOAD, S_SHIFT, S_ENDBYTE} state_t;

  state_t            state;
  logic              masterCfg, ienDone;
  logic [CNT_W-1:0]  burstCfg, txCfg, burstLeft, txLeft;
  logic [HALF_W-1:0] halfCnt;
  logic              wrCtrl, wrSta, launch, finish;

  assign wrCtrl = regWe && (regAddr == OFS_CTRL);
  assign wrSta  = regWe && (regAddr == OFS_ISTA);
  assign launch = wrCtrl && regWdata[CB_START] && regWdata[CB_EN] && !busy;
  assign finish = (state == S_CHECK) && (burstLeft == '0);

  // configuration and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enCfg      <= 1'b0;
      masterCfg  <= 1'b0;
      modeCfg    <= '0;
      discardCfg <= 1'b0;
      ienDone    <= 1'b0;
      doneSta    <= 1'b0;
      burstCfg   <= '0;
      txCfg      <= '0;
      busy       <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enCfg            <= regWdata[CB_EN];
        masterCfg        <= regWdata[CB_MASTER];
        modeCfg.cpha     <= regWdata[CB_CPHA];
        modeCfg.cpol     <= regWdata[CB_CPOL];
        modeCfg.lsbFirst <= regWdata[CB_LSB];
        discardCfg       <= regWdata[CB_DISCARD];
      end
      if (regWe && regAddr == OFS_IEN)   ienDone  <= regWdata[IB_DONE];
      if (regWe && regAddr == OFS_BURST) burstCfg <= regWdata[CNT_W-1:0];
      if (regWe && regAddr == OFS_TXLEN) txCfg    <= regWdata[CNT_W-1:0];
      if (finish)                            doneSta <= 1'b1;
      else if (wrSta && regWdata[IB_DONE])   doneSta <= 1'b0;
      if (launch)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;
    end
  end

  // byte sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      burstLeft <= '0;
      txLeft    <= '0;
      halfCnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (launch) begin
            burstLeft <= burstCfg;
            txLeft    <= txCfg;
            state     <= S_CHECK;
          end
        end
        S_CHECK: state <= finish ? S_IDLE : S_LOAD;
        S_LOAD: begin
          if (txLeft != '0) txLeft <= txLeft - 1'b1;
          halfCnt <= '0;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (halfTick) begin
            halfCnt <= halfCnt + 1'b1;
            if (halfCnt == HALF_LAST) state <= S_ENDBYTE;
          end
        end
        S_ENDBYTE: begin
          burstLeft <= burstLeft - 1'b1;
          state     <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clrTx     = wrCtrl && regWdata[CB_TXRST];
    strobe.clrRx     = wrCtrl && regWdata[CB_RXRST];
    strobe.pushTx    = regWe && (regAddr == OFS_TXDATA);
    strobe.popRx     = regRe && (regAddr == OFS_RXDATA);
    strobe.loadByte  = (state == S_LOAD);
    strobe.takeTx    = (state == S_LOAD) && (txLeft != '0);
    strobe.leadEdge  = (state == S_SHIFT) && halfTick && !halfCnt[0];
    strobe.trailEdge = (state == S_SHIFT) && halfTick && halfCnt[0];
    strobe.pushRx    = (state == S_ENDBYTE) && !discardCfg;
    strobe.active    = (state != S_IDLE);
    strobe.shifting  = (state == S_SHIFT);
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_RXDATA: regRdata[XFER_W-1:0] = rxHead;
      OFS_CTRL: begin
        regRdata[CB_EN]      = enCfg;
        regRdata[CB_MASTER]  = masterCfg;
        regRdata[CB_CPHA]    = modeCfg.cpha;
        regRdata[CB_CPOL]    = modeCfg.cpol;
        regRdata[CB_LSB]     = modeCfg.lsbFirst;
        regRdata[CB_START]   = busy;
        regRdata[CB_DISCARD] = discardCfg;
      end
      OFS_IEN:   regRdata[IB_DONE] = ienDone;
      OFS_ISTA:  regRdata[IB_DONE] = doneSta;
      OFS_BURST: regRdata[CNT_W-1:0] = burstCfg;
      OFS_TXLEN: regRdata[CNT_W-1:0] = txCfg;
      OFS_LEVEL: begin
        regRdata[LVL_W-1:0]            = rxLevel;
        regRdata[LB_TXLVL +: LVL_W]    = txLevel;
      end
      default: regRdata = '0;
    endcase
  end

  assign irq = ienDone && doneSta;

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              halfTick,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t         strobe;
  modeCfg_t          modeCfg;
  logic              busy, enCfg, discardCfg, doneSta;
  logic [LVL_W-1:0]  txLevel, rxLevel;
  logic [XFER_W-1:0] rxHead;

  spi_eng_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .halfTick(halfTick),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxHead(rxHead), .strobe(strobe),
    .modeCfg(modeCfg), .busy(busy), .enCfg(enCfg), .discardCfg(discardCfg),
    .doneSta(doneSta), .irq(irq)
  );

  spi_eng_dp #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeCfg(modeCfg),
    .txWdata(regWdata[XFER_W-1:0]), .miso(miso), .mosi(mosi), .sclk(sclk),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel)
  );

endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
  parameter int LVL_W = 7,
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             halfTick,
  input logic             sclk,
  input logic             cpol,
  input logic             enCfg,
  input logic             discardCfg,
  input logic             doneSta,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel
);

  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH)));

  p_launch_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> enCfg);

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol));

  p_sclk_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(halfTick) && $stable(cpol)) |-> $stable(sclk));

  p_discard_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && discardCfg) |=> (rxLevel <= $past(rxLevel)));

  p_done_on_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneSta);

endmodule

bind spi_byte_engine spi_byte_engine_chk #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .halfTick(halfTick), .sclk(sclk),
  .cpol(modeCfg.cpol), .enCfg(enCfg), .discardCfg(discardCfg),
  .doneSta(doneSta), .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/spi_byte_engine_tb.sv
module spi_byte_engine_tb;

  localparam logic [4:0] A_RX = 5'h00, A_TX = 5'h04, A_CTRL = 5'h08, A_IEN = 5'h0C,
                         A_STA = 5'h10, A_BURST = 5'h14, A_TXLEN = 5'h18, A_LVL = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        halfTick = 1'b0;
  logic        sclk, mosi, miso, irq;

  int total = 0;
  int bad = 0;

  logic [7:0] wireExp[$];
  logic       bCpol = 1'b0, bCpha = 1'b0, bLsb = 1'b0, watch = 1'b0;
  int         bitCnt = 0;
  logic [7:0] wireByte = '0;

  assign miso = ~mosi;

  always #5 clk = ~clk;

  spi_byte_engine u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .halfTick(halfTick),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  // half-period pulse source
  initial begin
    forever begin
      @(negedge clk);
      halfTick = ~halfTick;
    end
  end

  // wire monitor: decode mosi on the sample edge and compare with the scoreboard
  initial begin
    logic prevS;
    logic [7:0] expB;
    prevS = 1'b0;
    forever begin
      @(negedge clk);
      if (!watch) begin
        bitCnt = 0;
      end else if (sclk != prevS && sclk == (bCpol ~^ bCpha)) begin
        wireByte = bLsb ? {mosi, wireByte[7:1]} : {wireByte[6:0], mosi};
        bitCnt++;
        if (bitCnt == 8) begin
          bitCnt = 0;
          if (wireExp.size() == 0) begin
            chk("R6 unexpected byte on wire", {24'h0, wireByte}, 32'hDEAD);
          end else begin
            expB = wireExp.pop_front();
            chk("R6/R8 wire byte", {24'h0, wireByte}, {24'h0, expB});
          end
        end
      end
      prevS = sclk;
    end
  end

  task automatic runBurst(input logic [31:0] ctrlWord, input int burst, input int txn,
                          input logic [7:0] data [3], input string req);
    int n;
    logic [31:0] v;
    bCpol = ctrlWord[3]; bCpha = ctrlWord[2]; bLsb = ctrlWord[6];
    regWrite(A_CTRL, ctrlWord | 32'h300);
    chk({req, " R5 idle clock level"}, {31'h0, sclk}, {31'h0, bCpol});
    for (int i = 0; i < txn && i < 3; i++) regWrite(A_TX, {24'h0, data[i]});
    for (int i = 0; i < burst; i++) wireExp.push_back((i < txn) ? data[i] : 8'h00);
    regWrite(A_BURST, burst);
    regWrite(A_TXLEN, txn);
    watch = 1'b1;
    regWrite(A_CTRL, ctrlWord | 32'h400);
    n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " R10 irq at completion"}, {31'h0, irq}, 32'h1);
    repeat (2) @(negedge clk);
    watch = 1'b0;
    chk({req, " R6 no partial byte"}, bitCnt, 0);
    chk({req, " R6 all bytes seen"}, wireExp.size(), 0);
    regRead(A_CTRL, v);
    chk({req, " R10 start self-clears"}, {31'h0, v[10]}, 32'h0);
    chk({req, " R5 clock back at idle"}, {31'h0, sclk}, {31'h0, bCpol});
    regWrite(A_STA, 32'h0001_0000);
    chk({req, " R10 irq cleared"}, {31'h0, irq}, 32'h0);
  endtask

  task automatic expectRx(input logic [7:0] exp, input string req);
    logic [31:0] v;
    regRead(A_RX, v);
    chk(req, v, {24'h0, exp});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(A_CTRL, v);  chk("R1 control after reset", v, 32'h0);
    regRead(A_LVL, v);   chk("R1 levels after reset", v, 32'h0);
    regRead(A_STA, v);   chk("R1 status after reset", v, 32'h0);
    regRead(A_IEN, v);   chk("R1 enable after reset", v, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 sclk after reset", {31'h0, sclk}, 32'h0);
    chk("R1 mosi after reset", {31'h0, mosi}, 32'h0);

    // R2 levels and overflow, R3 reset pulses
    for (int i = 0; i < 3; i++) regWrite(A_TX, 32'h10 + i);
    regRead(A_LVL, v);   chk("R2 tx level after 3 pushes", v, 32'h0003_0000);
    regWrite(A_CTRL, 32'h100);
    regRead(A_LVL, v);   chk("R3 tx reset empties queue", v, 32'h0);
    regRead(A_CTRL, v);  chk("R3 reset bit reads zero", v, 32'h0);
    for (int i = 0; i < 65; i++) regWrite(A_TX, i);
    regRead(A_LVL, v);   chk("R2 tx level capped at 64", v, 32'h0040_0000);
    regWrite(A_CTRL, 32'h100);

    // R4 start without enable
    regWrite(A_IEN, 32'h0001_0000);
    regWrite(A_BURST, 1);
    regWrite(A_CTRL, 32'h400);
    repeat (60) @(negedge clk);
    regRead(A_CTRL, v);  chk("R4 start ignored without enable", v, 32'h0);
    regRead(A_STA, v);   chk("R4 no completion without enable", v, 32'h0);
    chk("R4 no irq without enable", {31'h0, irq}, 32'h0);

    // R6/R7 mode 0, MSB first
    runBurst(32'h3, 2, 2, '{8'hA5, 8'h3C, 8'h00}, "mode0");
    regRead(A_LVL, v);   chk("R7 rx level after 2 bytes", v, 32'h2);
    expectRx(8'h5A, "R7 first rx byte");
    expectRx(8'hC3, "R7 second rx byte");

    // R10 write-one-to-clear
    regWrite(A_BURST, 0);
    regWrite(A_CTRL, 32'h403);
    repeat (4) @(negedge clk);
    regWrite(A_STA, 32'h0);
    regRead(A_STA, v);   chk("R10 writing 0 keeps status", v, 32'h0001_0000);
    regWrite(A_STA, 32'h0001_0000);
    regRead(A_STA, v);   chk("R10 writing 1 clears status", v, 32'h0);

    // R5/R6 polarity 1, phase 1, LSB first
    runBurst(32'h4F, 2, 2, '{8'h1E, 8'hB2, 8'h00}, "mode3 lsb");
    expectRx(8'hE1, "R6 lsb first rx byte 0");
    expectRx(8'h4D, "R6 lsb first rx byte 1");

    // R8 zero padding, phase 1
    runBurst(32'h07, 3, 1, '{8'h96, 8'h00, 8'h00}, "mode1 pad");
    regRead(A_LVL, v);   chk("R8 tx drained, rx holds 3", v, 32'h3);
    expectRx(8'h69, "R8 rx of queued byte");
    regWrite(A_CTRL, 32'h207);
    regRead(A_LVL, v);   chk("R3 rx reset empties queue", v, 32'h0);
    expectRx(8'h00, "R7 empty read returns zero");

    // R8 transmit length zero, polarity 1 phase 0
    runBurst(32'h0B, 2, 0, '{8'h00, 8'h00, 8'h00}, "mode2 zero tx");
    expectRx(8'hFF, "R8 rx of pad byte 0");
    expectRx(8'hFF, "R8 rx of pad byte 1");

    // R9 discard
    runBurst(32'h8003, 2, 2, '{8'h11, 8'h22, 8'h00}, "discard");
    regRead(A_LVL, v);   chk("R9 discard leaves rx empty", v, 32'h0);

    // R11 zero-length burst
    runBurst(32'h3, 0, 0, '{8'h00, 8'h00, 8'h00}, "empty burst");
    regRead(A_LVL, v);   chk("R11 empty burst moves no data", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule